// File: doc/BRIEF.md
# Pixel Pseudo-Random Photon Counter

Each detector pixel counts comparator pulses in a shift register with linear feedback, not in a binary adder. Every accepted hit advances the register one step along a maximal-length sequence that starts from an all-ones seed. That seed stands for a count of zero. A later decoder maps the register value back to a hit count. The register can run at one of two lengths: a long length (20 bits by default) or a short length (16 bits by default). The length is latched when the register is preset.

A two-bit mode input selects one of three modes: counting, reading or standby. The mode also drives the enables for the analog front end, the counter and the serial port, which sit outside this block. In counting mode every hit steps the register. When the register is in the final state of its sequence, the next hit sets a sticky overflow flag and the count stops there. In reading mode the register acts as a segment of a serial chain. Each cycle with shift enable moves the register toward its most significant bit: the top bit of the active length goes out, and the serial input comes in at bit 0. Pixels can therefore be daisy-chained and read out one after another.

Top module: `pxc_pixel_counter`

## Requirements
- R1: After reset the long length is selected, the register holds the long all-ones seed (0xFFFFF by default) and overflow is 0.
- R2: Mode 2'b01 (counting) gives afe_en=1, ctr_en=1, ser_en=0. Mode 2'b10 (reading) gives afe_en=0, ctr_en=1, ser_en=1. Modes 2'b00 (standby) and 2'b11 (reserved) drive all three enables to 0.
- R3: A long-length step shifts the register left by one bit, and the new bit 0 is bit 19 XOR bit 2. Starting from 0xFFFFF, eight hits give 0xFFFFE, 0xFFFFC, 0xFFFF8, 0xFFFF1, 0xFFFE3, 0xFFFC7, 0xFFF8E, 0xFFF1C.
- R4: At the short length the seed is 0xFFFF, and bits above bit 15 stay 0. A step shifts left with new bit 0 = bit15^bit14^bit12^bit3, so four hits give 0xFFF0.
- R5: Hits have no effect in standby, reading or reserved mode.
- R6: When the register holds the last state, a hit sets overflow instead of stepping. The last state is the seed with its top bit cleared: 0x7FFFF (long) or 0x7FFF (short). Overflow then stays set and the register holds its value while further hits arrive.
- R7: Preset has priority over every other action and works in any mode. It loads the seed for the length on len_short (0 = long, 1 = short) and clears overflow.
- R8: The length changes only on preset. If len_short changes without a preset, the step rule does not change.
- R9: In reading mode, each cycle with shift_en high moves the active length one place toward its top bit: ser_out carries the top bit of the active length and ser_in enters bit 0. Outside reading mode ser_out is 0.
- R10: Shifting never changes overflow, and shift_en has no effect outside reading mode.
- R11: At the short length, 2^16-2 hits reach the last state without overflow, and hit number 2^16-1 sets overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 standby, 01 counting, 10 reading, 11 reserved (acts as standby) |
| len_short | input | 1 | Length to latch on preset: 0 long, 1 short |
| preset | input | 1 | Reload the seed and clear overflow |
| hit | input | 1 | Comparator hit pulse, one step per cycle |
| shift_en | input | 1 | Serial shift strobe used in reading mode |
| ser_in | input | 1 | Serial data from the previous pixel in the chain |
| ser_out | output | 1 | Serial data to the next pixel in the chain |
| overflow | output | 1 | Sticky overflow flag |
| afe_en | output | 1 | Front-end enable |
| ctr_en | output | 1 | Counter enable |
| ser_en | output | 1 | Serial port enable |

## Verification
The bench drives two instances with the same inputs. One uses the default 20/16-bit lengths. The other uses 8/5-bit lengths with tap masks 0xB8 and 0x14. The default instance confirms the literal sequences for both lengths and runs the complete 65535-state short cycle up to its overflow edge. The small instance brings long-length overflow (255 hits) and short-length overflow (31 hits) within a short run, and both instances are compared against a behavioural model on every clock.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

   typedef enum logic [1:0] {
      PXC_IDLE  = 2'b00,
      PXC_COUNT = 2'b01,
      PXC_READ  = 2'b10,
      PXC_RSVD  = 2'b11
   } pxc_mode_e;

   typedef enum logic {
      PXC_LEN_LONG  = 1'b0,
      PXC_LEN_SHORT = 1'b1
   } pxc_len_e;

   typedef struct packed {
      logic afe;
      logic ctr;
      logic ser;
   } pxc_en_t;

   localparam int PXC_MIN_W = 3;
   localparam int PXC_MAX_W = 32;

endpackage

// File: rtl/pxc_mode_ctrl.sv
module pxc_mode_ctrl
   import pxc_pkg::*;
(
   input  logic [1:0] mode_i,
   output pxc_en_t    en_o
);

   pxc_mode_e mode_e;

   always_comb begin
      mode_e = pxc_mode_e'(mode_i);
      en_o   = '0;
      unique case (mode_e)
         PXC_COUNT: begin
            en_o.afe = 1'b1;
            en_o.ctr = 1'b1;
         end
         PXC_READ: begin
            en_o.ctr = 1'b1;
            en_o.ser = 1'b1;
         end
         default: en_o = '0;
      endcase
   end

endmodule

// File: rtl/pxc_lfsr_step.sv
module pxc_lfsr_step
   import pxc_pkg::*;
#(
   parameter int             W    = 20,
   parameter logic [W-1:0]   TAPS = 20'h80004
)(
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o,
   output logic         at_last_o
);

   localparam logic [W-1:0] SEED      = {W{1'b1}};
   localparam logic [W-1:0] LAST      = {1'b0, {(W-1){1'b1}}};
   localparam int           LOW_TAPS  = $countones(TAPS[W-2:0]);

   generate
      if (W < PXC_MIN_W || W > PXC_MAX_W) begin : g_bad_w
         $error("pxc_lfsr_step: width out of range");
      end
      if (TAPS[W-1] != 1'b1) begin : g_bad_msb
         $error("pxc_lfsr_step: feedback must include the top bit");
      end
      if ((LOW_TAPS % 2) == 0) begin : g_bad_par
         $error("pxc_lfsr_step: odd lower tap count needed for an all-ones seed");
      end
   endgenerate

   logic fb;

   always_comb begin
      fb        = ^(cur_i & TAPS);
      nxt_o     = {cur_i[W-2:0], fb};
      at_last_o = (cur_i == LAST);
   end

   logic unused_seed;
   assign unused_seed = ^SEED;

endmodule

// File: rtl/pxc_ser_path.sv
module pxc_ser_path
   import pxc_pkg::*;
#(
   parameter int LONG_W  = 20,
   parameter int SHORT_W = 16
)(
   input  logic [LONG_W-1:0] state_i,
   input  pxc_len_e          len_i,
   input  logic              ser_en_i,
   input  logic              ser_in_i,
   output logic [LONG_W-1:0] shifted_o,
   output logic              ser_out_o
);

   localparam int PAD = LONG_W - SHORT_W;

   logic [LONG_W-1:0] sh_long;
   logic [LONG_W-1:0] sh_short;
   logic              top_bit;

   always_comb begin
      sh_long  = {state_i[LONG_W-2:0], ser_in_i};
      sh_short = {{PAD{1'b0}}, state_i[SHORT_W-2:0], ser_in_i};
      if (len_i == PXC_LEN_SHORT) begin
         shifted_o = sh_short;
         top_bit   = state_i[SHORT_W-1];
      end else begin
         shifted_o = sh_long;
         top_bit   = state_i[LONG_W-1];
      end
      ser_out_o = ser_en_i & top_bit;
   end

endmodule

// File: rtl/pxc_count_core.sv
module pxc_count_core
   import pxc_pkg::*;
#(
   parameter int                  LONG_W     = 20,
   parameter int                  SHORT_W    = 16,
   parameter logic [LONG_W-1:0]   LONG_TAPS  = 20'h80004,
   parameter logic [SHORT_W-1:0]  SHORT_TAPS = 16'hD008
)(
   input  logic              clk,
   input  logic              rst_n,
   input  pxc_en_t           en_i,
   input  logic              hit_i,
   input  logic              preset_i,
   input  logic              len_short_i,
   input  logic              shift_en_i,
   input  logic              ser_in_i,
   output logic [LONG_W-1:0] state_o,
   output pxc_len_e          len_o,
   output logic              ovf_o,
   output logic              ser_out_o
);

   localparam int                PAD        = LONG_W - SHORT_W;
   localparam logic [LONG_W-1:0] LONG_SEED  = {LONG_W{1'b1}};
   localparam logic [LONG_W-1:0] SHORT_SEED = {{PAD{1'b0}}, {SHORT_W{1'b1}}};

   logic [LONG_W-1:0]  state_q;
   pxc_len_e           len_q;
   logic               ovf_q;

   logic [LONG_W-1:0]  long_nxt;
   logic               long_last;
   logic [SHORT_W-1:0] short_nxt;
   logic               short_last;
   logic [LONG_W-1:0]  step_val;
   logic               at_last;
   logic [LONG_W-1:0]  shift_val;
   logic               count_go;
   logic               shift_go;

   generate
      begin : g_long
         pxc_lfsr_step #(
            .W    (LONG_W),
            .TAPS (LONG_TAPS)
         ) u_step (
            .cur_i     (state_q),
            .nxt_o     (long_nxt),
            .at_last_o (long_last)
         );
      end
      begin : g_short
         pxc_lfsr_step #(
            .W    (SHORT_W),
            .TAPS (SHORT_TAPS)
         ) u_step (
            .cur_i     (state_q[SHORT_W-1:0]),
            .nxt_o     (short_nxt),
            .at_last_o (short_last)
         );
      end
   endgenerate

   pxc_ser_path #(
      .LONG_W  (LONG_W),
      .SHORT_W (SHORT_W)
   ) u_ser (
      .state_i   (state_q),
      .len_i     (len_q),
      .ser_en_i  (en_i.ser),
      .ser_in_i  (ser_in_i),
      .shifted_o (shift_val),
      .ser_out_o (ser_out_o)
   );

   always_comb begin
      if (len_q == PXC_LEN_SHORT) begin
         step_val = {{PAD{1'b0}}, short_nxt};
         at_last  = short_last;
      end else begin
         step_val = long_nxt;
         at_last  = long_last;
      end
      count_go = en_i.afe & en_i.ctr & hit_i & ~ovf_q;
      shift_go = en_i.ser & en_i.ctr & shift_en_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LONG_SEED;
         len_q   <= PXC_LEN_LONG;
         ovf_q   <= 1'b0;
      end else if (preset_i) begin
         len_q   <= pxc_len_e'(len_short_i);
         state_q <= len_short_i ? SHORT_SEED : LONG_SEED;
         ovf_q   <= 1'b0;
      end else if (count_go) begin
         if (at_last) begin
            ovf_q <= 1'b1;
         end else begin
            state_q <= step_val;
         end
      end else if (shift_go) begin
         state_q <= shift_val;
      end
   end

   assign state_o = state_q;
   assign len_o   = len_q;
   assign ovf_o   = ovf_q;

endmodule

// File: rtl/pxc_pixel_counter.sv
module pxc_pixel_counter
   import pxc_pkg::*;
#(
   parameter int                  LONG_W     = 20,
   parameter int                  SHORT_W    = 16,
   parameter logic [LONG_W-1:0]   LONG_TAPS  = 20'h80004,
   parameter logic [SHORT_W-1:0]  SHORT_TAPS = 16'hD008
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       len_short,
   input  logic       preset,
   input  logic       hit,
   input  logic       shift_en,
   input  logic       ser_in,
   output logic       ser_out,
   output logic       overflow,
   output logic       afe_en,
   output logic       ctr_en,
   output logic       ser_en
);

   generate
      if (SHORT_W >= LONG_W) begin : g_bad_len
         $error("pxc_pixel_counter: short length must be below long length");
      end
      if (SHORT_W < PXC_MIN_W) begin : g_bad_short
         $error("pxc_pixel_counter: short length too small");
      end
   endgenerate

   pxc_en_t           en;
   logic [LONG_W-1:0] state_w;
   pxc_len_e          len_w;

   pxc_mode_ctrl u_mode (
      .mode_i (mode),
      .en_o   (en)
   );

   pxc_count_core #(
      .LONG_W     (LONG_W),
      .SHORT_W    (SHORT_W),
      .LONG_TAPS  (LONG_TAPS),
      .SHORT_TAPS (SHORT_TAPS)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en),
      .hit_i       (hit),
      .preset_i    (preset),
      .len_short_i (len_short),
      .shift_en_i  (shift_en),
      .ser_in_i    (ser_in),
      .state_o     (state_w),
      .len_o       (len_w),
      .ovf_o       (overflow),
      .ser_out_o   (ser_out)
   );

   assign afe_en = en.afe;
   assign ctr_en = en.ctr;
   assign ser_en = en.ser;

endmodule

// File: rtl/pxc_pixel_counter_chk.sv
module pxc_pixel_counter_chk
   import pxc_pkg::*;
#(
   parameter int LONG_W  = 20,
   parameter int SHORT_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              preset,
   input logic              hit,
   input logic              ser_out,
   input logic              overflow,
   input logic              afe_en,
   input logic              ser_en,
   input logic [LONG_W-1:0] state_w,
   input pxc_len_e          len_w
);

   // R2
   enables_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(afe_en && ser_en));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b01 && mode != 2'b10 && !preset) |=> $stable(state_w));

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !preset) |=> overflow);

   // R6
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && hit && mode == 2'b01 && !preset) |=> $stable(state_w));

   // R7
   preset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> !overflow);

   // R9
   ser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_en |-> !ser_out);

   // R10
   shift_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && !preset) |=> overflow == $past(overflow));

   // R4
   short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_w == PXC_LEN_SHORT) |-> (state_w[LONG_W-1:SHORT_W] == '0));

endmodule

bind pxc_pixel_counter pxc_pixel_counter_chk #(
   .LONG_W  (LONG_W),
   .SHORT_W (SHORT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .preset   (preset),
   .hit      (hit),
   .ser_out  (ser_out),
   .overflow (overflow),
   .afe_en   (afe_en),
   .ser_en   (ser_en),
   .state_w  (state_w),
   .len_w    (len_w)
);

// File: tb/pxc_pixel_counter_tb.sv
`timescale 1ns/1ps
module pxc_pixel_counter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       len_short = 1'b0;
   logic       preset = 1'b0;
   logic       hit = 1'b0;
   logic       shift_en = 1'b0;
   logic       ser_in = 1'b0;

   logic so[2], ov[2], ae[2], ce[2], se[2];

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pxc_pixel_counter u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .len_short(len_short),
      .preset(preset), .hit(hit), .shift_en(shift_en), .ser_in(ser_in),
      .ser_out(so[0]), .overflow(ov[0]), .afe_en(ae[0]), .ctr_en(ce[0]), .ser_en(se[0])
   );

   pxc_pixel_counter #(
      .LONG_W(8), .SHORT_W(5), .LONG_TAPS(8'hB8), .SHORT_TAPS(5'h14)
   ) u_dut_small (
      .clk(clk), .rst_n(rst_n), .mode(mode), .len_short(len_short),
      .preset(preset), .hit(hit), .shift_en(shift_en), .ser_in(ser_in),
      .ser_out(so[1]), .overflow(ov[1]), .afe_en(ae[1]), .ctr_en(ce[1]), .ser_en(se[1])
   );

   // reference model
   int unsigned lw[2] = '{20, 8};
   int unsigned sw[2] = '{16, 5};
   int unsigned lm[2] = '{32'h80004, 32'hB8};
   int unsigned sm[2] = '{32'hD008, 32'h14};
   int unsigned ms[2];
   bit          mshort[2];
   bit          movf[2];

   function automatic int unsigned wmask(int unsigned w);
      return (32'd1 << w) - 1;
   endfunction

   function automatic int unsigned mstep(int unsigned s, int unsigned w, int unsigned m);
      int unsigned fb = $countones(s & m) % 2;
      return ((s << 1) & wmask(w)) | fb;
   endfunction

   task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         int unsigned w = mshort[i] ? sw[i] : lw[i];
         int unsigned m = mshort[i] ? sm[i] : lm[i];
         if (!rst_n) begin
            ms[i] = wmask(lw[i]); mshort[i] = 1'b0; movf[i] = 1'b0;
         end else if (preset) begin
            mshort[i] = len_short;
            ms[i] = len_short ? wmask(sw[i]) : wmask(lw[i]);
            movf[i] = 1'b0;
         end else if (mode == 2'b01 && hit && !movf[i]) begin
            if (ms[i] == (wmask(w) >> 1)) movf[i] = 1'b1;
            else ms[i] = mstep(ms[i], w, m);
         end else if (mode == 2'b10 && shift_en) begin
            ms[i] = ((ms[i] << 1) & wmask(w)) | 32'(ser_in);
         end
      end
   end

   // per-cycle comparison against the model (R2, R9, R6)
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 2; i++) begin
            int unsigned w = mshort[i] ? sw[i] : lw[i];
            bit e_so = (mode == 2'b10) ? bit'((ms[i] >> (w - 1)) & 1) : 1'b0;
            bit e_ae = (mode == 2'b01);
            bit e_ce = (mode == 2'b01) || (mode == 2'b10);
            bit e_se = (mode == 2'b10);
            int unsigned act = {so[i], ov[i], ae[i], ce[i], se[i]};
            int unsigned exp = {e_so, movf[i], e_ae, e_ce, e_se};
            chk(act == exp, "R9/R6/R2 model", act, exp);
         end
      end
   end

   task automatic do_preset(input bit s);
      preset = 1'b1; len_short = s;
      @(posedge clk); #1;
      preset = 1'b0;
   endtask

   task automatic hits(input int n);
      mode = 2'b01; hit = 1'b1;
      repeat (n) @(posedge clk);
      #1;
      hit = 1'b0; mode = 2'b00;
   endtask

   task automatic readout(input int w, input int unsigned pat, output int unsigned got);
      got = 0; mode = 2'b10; shift_en = 1'b1;
      for (int i = 0; i < w; i++) begin
         ser_in = bit'((pat >> (w - 1 - i)) & 1);
         @(negedge clk);
         got = (got << 1) | 32'(so[0]);
         @(posedge clk); #1;
      end
      shift_en = 1'b0; mode = 2'b00; ser_in = 1'b0;
   endtask

   bit finished = 1'b0;

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned got;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk(ov[0] == 1'b0, "R1 overflow after reset", ov[0], 0);
      @(posedge clk); #1;
      readout(20, 0, got);
      chk(got == 32'hFFFFF, "R1 seed after reset", got, 32'hFFFFF);

      // R3: long sequence
      do_preset(1'b0);
      hits(8);
      readout(20, 0, got);
      chk(got == 32'hFFF1C, "R3 eight long steps", got, 32'hFFF1C);

      // R2: enables in each mode
      for (int m = 0; m < 4; m++) begin
         int unsigned exp;
         mode = 2'(m);
         @(negedge clk);
         exp = (m == 1) ? 3'b110 : (m == 2) ? 3'b011 : 3'b000;
         chk({ae[0], ce[0], se[0]} == 3'(exp), "R2 mode enables", {ae[0], ce[0], se[0]}, exp);
         @(posedge clk); #1;
      end
      mode = 2'b00;

      // R4: short sequence
      do_preset(1'b1);
      hits(4);
      readout(16, 0, got);
      chk(got == 32'hFFF0, "R4 four short steps", got, 32'hFFF0);

      // R8: length latched only on preset
      do_preset(1'b0);
      len_short = 1'b1;
      hits(3);
      readout(20, 0, got);
      chk(got == 32'hFFFF8, "R8 length unchanged without preset", got, 32'hFFFF8);
      len_short = 1'b0;

      // R5: hits ignored outside counting mode
      do_preset(1'b0);
      hit = 1'b1;
      mode = 2'b00; repeat (10) @(posedge clk);
      #1 mode = 2'b10; repeat (10) @(posedge clk);
      #1 mode = 2'b11; repeat (10) @(posedge clk);
      #1 hit = 1'b0; mode = 2'b00;
      readout(20, 0, got);
      chk(got == 32'hFFFFF, "R5 hits ignored", got, 32'hFFFFF);

      // R9: daisy-chain load and quiet output in standby
      readout(20, 32'hA5A5A, got);
      readout(20, 0, got);
      chk(got == 32'hA5A5A, "R9 serial chain load", got, 32'hA5A5A);
      do_preset(1'b0);
      @(negedge clk);
      chk(so[0] == 1'b0, "R9 ser_out quiet in standby", so[0], 0);
      @(posedge clk); #1;

      // R10: shift_en ignored outside reading mode
      shift_en = 1'b1; mode = 2'b01;
      repeat (5) @(posedge clk);
      #1 mode = 2'b00; repeat (5) @(posedge clk);
      #1 shift_en = 1'b0;
      readout(20, 0, got);
      chk(got == 32'hFFFFF, "R10 shift ignored outside reading", got, 32'hFFFFF);

      // R11 / R6: full short cycle
      do_preset(1'b1);
      hits(65534);
      @(negedge clk);
      chk(ov[0] == 1'b0, "R11 no overflow at last state", ov[0], 0);
      @(posedge clk); #1;
      hits(1);
      @(negedge clk);
      chk(ov[0] == 1'b1, "R11 overflow on final hit", ov[0], 1);
      @(posedge clk); #1;
      hits(5);
      readout(16, 0, got);
      chk(got == 32'h7FFF, "R6 count saturated", got, 32'h7FFF);
      @(negedge clk);
      chk(ov[0] == 1'b1, "R10 overflow kept through shift", ov[0], 1);
      @(posedge clk); #1;
      do_preset(1'b1);
      @(negedge clk);
      chk(ov[0] == 1'b0, "R7 preset clears overflow", ov[0], 0);
      @(posedge clk); #1;

      // R6: small instance, both lengths
      do_preset(1'b0);
      hits(254);
      @(negedge clk);
      chk(ov[1] == 1'b0, "R6 small long before overflow", ov[1], 0);
      @(posedge clk); #1;
      hits(1);
      @(negedge clk);
      chk(ov[1] == 1'b1, "R6 small long overflow", ov[1], 1);
      @(posedge clk); #1;
      do_preset(1'b1);
      hits(30);
      @(negedge clk);
      chk(ov[1] == 1'b0, "R6 small short before overflow", ov[1], 0);
      @(posedge clk); #1;
      hits(1);
      @(negedge clk);
      chk(ov[1] == 1'b1, "R6 small short overflow", ov[1], 1);
      @(posedge clk); #1;

      // R7: preset wins over a simultaneous hit
      mode = 2'b01; hit = 1'b1; preset = 1'b1; len_short = 1'b0;
      @(posedge clk); #1;
      preset = 1'b0; hit = 1'b0; mode = 2'b00;
      readout(20, 0, got);
      chk(got == 32'hFFFFF, "R7 preset priority", got, 32'hFFFFF);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule